// File: doc/BRIEF.md
# External Trigger Timestamp Capture Queue

This block watches two asynchronous trigger inputs and, on the chosen edge of each, copies the current 64-bit time value into a queue for that input. Each queue keeps its stamps in arrival order. Software reads the oldest stamp through a low word and a high word, and a status bit shows whether stamps are waiting. The time counter lives outside the block and reaches it on `time_i`.

Each input raises three kinds of event. A new-stamp event marks an accepted capture. A threshold event marks the queue fill reaching a programmable level. An overflow event marks a capture that was dropped because the queue was full. Events stay set until software clears them by writing ones. A mask register chooses which of them drive the single interrupt output.

The register port is a simple synchronous word bus. A write takes effect on the clock edge where `wr_en` is high. A read returns its data on `rdata` one cycle after `rd_en`.

Top module: `trig_stamp_capture`

## Requirements
- R1: Each trigger passes through two synchronizing flops before its edge is detected. The stored stamp is the `time_i` value present in the cycle after the second flop takes the new level, which is three clock edges after the input changes.
- R2: Bit 8+i of the control register (address 0x0) sets the edge for input i: 1 captures falling edges and 0 captures rising edges. The other edge produces no capture.
- R3: Bit 24+i of the status register (address 0x3, read only) is 1 while queue i holds at least one stamp, and 0 otherwise.
- R4: Address 0x8+2i returns bits 31:0 of the oldest stamp of queue i. Address 0x9+2i returns bits 63:32 of the same stamp and removes it from the queue. Stamps come out in capture order.
- R5: A read of either word of an empty queue returns zero and leaves the queue empty.
- R6: Bit 24+i of the event register (address 0x1) is set by every capture that queue i accepts.
- R7: Bit 20+i of the event register is set when an accepted capture brings queue i's fill level to at least the value in the threshold register (address 0x4, 5 bits). The threshold resets to 7.
- R8: Each queue holds 16 stamps. A capture that arrives while the queue is full is dropped. It sets event bit 28+i, it does not set bit 24+i, and it leaves the stored stamps unchanged.
- R9: Event bits stay set until a write to address 0x1 carries a 1 in their position. Writing 0 has no effect. A new event in the same cycle as its clear wins.
- R10: `irq_o` is 1 exactly one cycle after any event bit is set whose bit in the mask register (address 0x2) is also 1.
- R11: After reset the queues are empty, the control, event and mask registers are zero, the threshold is 7, and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 2 | Asynchronous trigger inputs, one bit per input |
| time_i | input | 64 | Current time from the external counter |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one cycle after `rd_en` |
| irq_o | output | 1 | Masked event interrupt |

## Verification
The bench drives a capture on the edge that should be ignored and checks that no stamp appears. A design that ignored the polarity bit, or that detected both edges, would leave an extra entry. It fills a queue to exactly 16 stamps, sends one more, and then drains the queue and compares every stamp. A design that overwrote the newest entry, wrapped a pointer, or still raised new-stamp on a drop would return a wrong value or set the wrong event bit. The bench checks that the threshold event does not fire one capture early, that a zero write leaves events set, and that reads from an empty queue return zero. It also checks that a stamp sits exactly three edges behind its trigger, which catches a synchronizer that is one stage short or one stage long.

// File: rtl/trig_stamp_pkg.sv
package trig_stamp_pkg;
  localparam int REG_AW   = 4;
  localparam int EDGE_LSB = 8;
  localparam int THR_LSB  = 20;
  localparam int NEW_LSB  = 24;
  localparam int OVF_LSB  = 28;
  localparam int VLD_LSB  = 24;

  localparam logic [REG_AW-1:0] A_CTRL  = 4'h0;
  localparam logic [REG_AW-1:0] A_EVT   = 4'h1;
  localparam logic [REG_AW-1:0] A_MASK  = 4'h2;
  localparam logic [REG_AW-1:0] A_STAT  = 4'h3;
  localparam logic [REG_AW-1:0] A_LEVEL = 4'h4;
  localparam logic [REG_AW-1:0] A_QBASE = 4'h8;

  function automatic logic [REG_AW-1:0] q_lo_addr(input int idx);
    return REG_AW'(int'(A_QBASE) + 2 * idx);
  endfunction

  function automatic logic [REG_AW-1:0] q_hi_addr(input int idx);
    return REG_AW'(int'(A_QBASE) + 2 * idx + 1);
  endfunction
endpackage

// File: rtl/trig_edge_sync.sv
module trig_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic trig_i,
  input  logic fall_sel,
  output logic hit
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= trig_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  // Polarity only picks which transition of the settled level counts.
  assign hit = fall_sel ? (prev_q & ~s2_q) : (s2_q & ~prev_q);
endmodule

// File: rtl/stamp_fifo.sv
module stamp_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int LW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic          full,
  output logic [LW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      if (do_push && !do_pop)      level <= level + 1'b1;
      else if (do_pop && !do_push) level <= level - 1'b1;
    end
  end

  assign dout = mem[rd_ptr];
endmodule

// File: rtl/stamp_events.sv
module stamp_events #(
  parameter int N  = 2,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  new_hit,
  input  logic [N-1:0]  thr_hit,
  input  logic [N-1:0]  ovf_hit,
  input  logic          clr_we,
  input  logic [DW-1:0] clr_bits,
  input  logic [DW-1:0] mask,
  output logic [DW-1:0] evt_q,
  output logic          irq_q
);
  import trig_stamp_pkg::*;
  logic [DW-1:0] set_vec;

  always_comb begin
    set_vec = '0;
    for (int i = 0; i < N; i++) begin
      set_vec[THR_LSB + i] = thr_hit[i];
      set_vec[NEW_LSB + i] = new_hit[i];
      set_vec[OVF_LSB + i] = ovf_hit[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      evt_q <= (evt_q & ~(clr_we ? clr_bits : '0)) | set_vec;
      irq_q <= |(evt_q & mask);
    end
  end
endmodule

// File: rtl/trig_stamp_capture.sv
module trig_stamp_capture #(
  parameter int N_IN    = 2,
  parameter int DEPTH   = 16,
  parameter int TW      = 64,
  parameter int DW      = 32,
  parameter int THR_RST = 7,
  localparam int LW     = $clog2(DEPTH) + 1,
  localparam int AW     = trig_stamp_pkg::REG_AW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_IN-1:0] trig_i,
  input  logic [TW-1:0]   time_i,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            irq_o
);
  import trig_stamp_pkg::*;

  logic [N_IN-1:0] fall_q;
  logic [DW-1:0]   mask_q;
  logic [LW-1:0]   thr_q;
  logic [DW-1:0]   evt_q;

  logic [N_IN-1:0] hit, vld, full, pop, new_hit, thr_hit, ovf_hit;
  logic [TW-1:0]   head [N_IN];
  logic [LW-1:0]   lvl  [N_IN];

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    logic empty_i;

    trig_edge_sync u_sync (
      .clk(clk), .rst(rst), .trig_i(trig_i[i]), .fall_sel(fall_q[i]), .hit(hit[i])
    );

    assign pop[i] = rd_en && (addr == q_hi_addr(i));

    stamp_fifo #(.W(TW), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst(rst), .push(hit[i]), .din(time_i), .pop(pop[i]),
      .dout(head[i]), .empty(empty_i), .full(full[i]), .level(lvl[i])
    );

    assign vld[i]     = ~empty_i;
    assign new_hit[i] = hit[i] & ~full[i];
    assign ovf_hit[i] = hit[i] & full[i];
    assign thr_hit[i] = new_hit[i] && (({1'b0, lvl[i]} + 1'b1) >= {1'b0, thr_q});
  end

  stamp_events #(.N(N_IN), .DW(DW)) u_evt (
    .clk(clk), .rst(rst), .new_hit(new_hit), .thr_hit(thr_hit), .ovf_hit(ovf_hit),
    .clr_we(wr_en && (addr == A_EVT)), .clr_bits(wdata), .mask(mask_q),
    .evt_q(evt_q), .irq_q(irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fall_q <= '0;
      mask_q <= '0;
      thr_q  <= LW'(THR_RST);
    end else if (wr_en) begin
      case (addr)
        A_CTRL:  fall_q <= wdata[EDGE_LSB +: N_IN];
        A_MASK:  mask_q <= wdata;
        A_LEVEL: thr_q  <= wdata[LW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= '0;
      case (addr)
        A_CTRL:  rdata[EDGE_LSB +: N_IN] <= fall_q;
        A_EVT:   rdata <= evt_q;
        A_MASK:  rdata <= mask_q;
        A_STAT:  rdata[VLD_LSB +: N_IN] <= vld;
        A_LEVEL: rdata[LW-1:0] <= thr_q;
        default: ;
      endcase
      for (int i = 0; i < N_IN; i++) begin
        if (vld[i] && addr == q_lo_addr(i)) rdata <= head[i][DW-1:0];
        if (vld[i] && addr == q_hi_addr(i)) rdata <= head[i][TW-1:DW];
      end
    end
  end
endmodule

// File: rtl/trig_stamp_capture_chk.sv
module trig_stamp_capture_chk #(
  parameter int N_IN  = 2,
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  parameter int LW    = 5,
  parameter int AW    = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            rd_en,
  input logic            wr_en,
  input logic [AW-1:0]   addr,
  input logic [DW-1:0]   rdata,
  input logic            irq_o,
  input logic [DW-1:0]   evt_q,
  input logic [DW-1:0]   mask_q,
  input logic [N_IN-1:0] vld,
  input logic [LW-1:0]   lvl [N_IN]
);
  import trig_stamp_pkg::*;
  logic rd_empty;

  always_comb begin
    rd_empty = 1'b0;
    for (int i = 0; i < N_IN; i++)
      if (rd_en && !vld[i] && (addr == q_lo_addr(i) || addr == q_hi_addr(i))) rd_empty = 1'b1;
  end

  // R5: a read of an empty queue returns zero
  a_r5_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
    rd_empty |=> (rdata == '0));

  // R9: event bits clear only by a write to the event register
  a_r9_evt_sticky: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en && addr == A_EVT) |-> ((~evt_q & $past(evt_q)) == '0));

  // R10: interrupt only follows a masked event
  a_r10_irq_source: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past((evt_q & mask_q) != '0));

  a_r10_irq_raise: assert property (@(posedge clk) disable iff (rst)
    ((evt_q & mask_q) != '0) |=> irq_o);

  for (genvar i = 0; i < N_IN; i++) begin : g_q
    // R8: fill never exceeds the queue depth
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
      lvl[i] <= LW'(DEPTH));
    // R3: the valid flag drops only after a high-word read
    a_r3_valid_fall: assert property (@(posedge clk) disable iff (rst)
      $fell(vld[i]) |-> $past(rd_en && addr == q_hi_addr(i)));
  end
endmodule

bind trig_stamp_capture trig_stamp_capture_chk #(
  .N_IN(N_IN), .DEPTH(DEPTH), .DW(DW), .LW(LW), .AW(AW)
) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .rdata(rdata),
  .irq_o(irq_o), .evt_q(evt_q), .mask_q(mask_q), .vld(vld), .lvl(lvl)
);

// File: tb/trig_stamp_capture_tb.sv
`timescale 1ns/1ps
module trig_stamp_capture_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  trig_i = '0;
  logic [63:0] tcount = 64'h0000_0005_0000_0100;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_o;

  int checks = 0, errors = 0;
  logic [63:0] sb0 [$];
  logic [63:0] sb1 [$];
  logic [1:0]  pol = '0;
  int          fill [2] = '{0, 0};

  always #2.5 clk = ~clk;
  always @(posedge clk) tcount <= tcount + 1;

  trig_stamp_capture u_dut (
    .clk(clk), .rst(rst), .trig_i(trig_i), .time_i(tcount), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  // Driver: change a trigger level and, if it is the selected edge, predict the stamp.
  task automatic drive(input int i, input logic v);
    logic old;
    logic [63:0] t;
    @(negedge clk);
    old = trig_i[i];
    t = tcount;
    trig_i[i] = v;
    if ((pol[i] == 1'b0 && !old && v) || (pol[i] == 1'b1 && old && !v)) begin
      if (fill[i] < 16) begin
        fill[i]++;
        if (i == 0) sb0.push_back(t + 64'd2); else sb1.push_back(t + 64'd2);
      end
    end
    repeat (5) @(negedge clk);
  endtask

  task automatic capture(input int i);
    if (pol[i]) begin drive(i, 1'b1); drive(i, 1'b0); end
    else        begin drive(i, 1'b1); drive(i, 1'b0); end
  endtask

  // Monitor: drain one stamp and compare it with the scoreboard head.
  task automatic drain_one(input int i, input string req);
    logic [31:0] lo, hi;
    logic [63:0] exp;
    bus_rd(4'(8 + 2 * i), lo);
    bus_rd(4'(9 + 2 * i), hi);
    exp = (i == 0) ? sb0.pop_front() : sb1.pop_front();
    fill[i]--;
    check(req, {hi, lo}, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    check("R11 irq", {63'd0, irq_o}, 64'd0);
    bus_rd(4'h3, d); check("R11 status", {32'd0, d}, 64'd0);
    bus_rd(4'h1, d); check("R11 event", {32'd0, d}, 64'd0);
    bus_rd(4'h0, d); check("R11 ctrl", {32'd0, d}, 64'd0);
    bus_rd(4'h2, d); check("R11 mask", {32'd0, d}, 64'd0);
    bus_rd(4'h4, d); check("R11 R7 threshold default", {32'd0, d}, 64'd7);

    // R5 empty reads
    bus_rd(4'h8, d); check("R5 empty low", {32'd0, d}, 64'd0);
    bus_rd(4'h9, d); check("R5 empty high", {32'd0, d}, 64'd0);

    // R1 R2 rising edge on input 0, falling edge ignored
    capture(0);
    bus_rd(4'h3, d); check("R3 valid set", {63'd0, d[24]}, 64'd1);
    bus_rd(4'h1, d); check("R6 new stamp 0", {63'd0, d[24]}, 64'd1);
    drain_one(0, "R1 R4 stamp input0");
    bus_rd(4'h3, d); check("R2 R3 falling ignored, queue empty", {63'd0, d[24]}, 64'd0);

    // R2 falling polarity on input 1
    bus_wr(4'h0, 32'h0000_0200); pol[1] = 1'b1;
    drive(1, 1'b1);
    bus_rd(4'h3, d); check("R2 rising ignored on input1", {63'd0, d[25]}, 64'd0);
    drive(1, 1'b0);
    bus_rd(4'h3, d); check("R2 falling captured on input1", {63'd0, d[25]}, 64'd1);
    bus_rd(4'h1, d); check("R6 new stamp 1", {63'd0, d[25]}, 64'd1);
    drain_one(1, "R1 R4 stamp input1");

    // R10 R9 interrupt and clear
    bus_wr(4'h2, 32'h0100_0000);
    @(negedge clk);
    check("R10 irq on masked event", {63'd0, irq_o}, 64'd1);
    bus_wr(4'h1, 32'h0000_0000);
    bus_rd(4'h1, d); check("R9 zero write keeps event", {63'd0, d[24]}, 64'd1);
    bus_wr(4'h1, 32'h0100_0000);
    @(negedge clk);
    bus_rd(4'h1, d); check("R9 w1c clears", {63'd0, d[24]}, 64'd0);
    check("R10 irq drops", {63'd0, irq_o}, 64'd0);
    bus_wr(4'h1, 32'hFFFF_FFFF);
    bus_wr(4'h2, 32'h0000_0000);

    // R7 threshold at 3
    bus_wr(4'h4, 32'd3);
    capture(0); capture(0);
    bus_rd(4'h1, d); check("R7 no threshold at 2", {63'd0, d[20]}, 64'd0);
    capture(0);
    bus_rd(4'h1, d); check("R7 threshold at 3", {63'd0, d[20]}, 64'd1);
    check("R7 other input untouched", {63'd0, d[21]}, 64'd0);

    // R8 fill to 16, then overflow
    for (int k = 0; k < 13; k++) capture(0);
    bus_wr(4'h1, 32'hFFFF_FFFF);
    capture(0);
    bus_rd(4'h1, d);
    check("R8 overflow event", {63'd0, d[28]}, 64'd1);
    check("R8 no new stamp on drop", {63'd0, d[24]}, 64'd0);
    for (int k = 0; k < 16; k++) drain_one(0, "R8 R4 drain full queue");
    bus_rd(4'h3, d); check("R3 valid clear after drain", {63'd0, d[24]}, 64'd0);
    bus_rd(4'h8, d); check("R5 empty after drain", {32'd0, d}, 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule